// File: doc/BRIEF.md
# Cycle, Timer and Retired-Instruction Counter Unit

This unit holds the three timekeeping counters of a small in-order 32-bit integer core. It has a free-running cycle counter, a down-counting timer that requests an interrupt when it expires, and a counter of useful (non-NOP) instructions that leave the last pipeline stage. The core reads them with a set-bits CSR access whose source register is x0, and writes them with a swap-style CSR access.

Reads pass through a fixed two-stage return path. The result shows up two cycles after the request, and the value it carries is skewed by the same two cycles. The cycle counter reads ahead by two. The timer reads behind by two and saturates at zero. The retired counter is returned as it stood when the request was made.

The timer stops at zero. Loading zero therefore switches it off, and no further request is raised until a nonzero value is loaded.

Top module: `ctr_csr_unit`

## Requirements
- R1: After reset all three counters are 0, `timer_irq` is low and `rd_vld` is low.
- R2: The cycle counter (CSR 0xC00) rises by exactly one on every clock, and wraps from 0xFFFFFFFF to 0, unless it is written in that clock.
- R3: A read accepted in cycle t raises `rd_vld` in cycle t+2 and in no other cycle. For address 0xC00, `rd_data` then equals C0+2 (modulo 2^32), where C0 is the cycle counter value during cycle t.
- R4: The timer (CSR 0xC01) falls by one per clock while it is nonzero. `timer_irq` is high for exactly the one cycle in which the timer first holds 0 after counting down from 1.
- R5: A timer at 0, whether it counted there or was written 0, stays 0 and raises no `timer_irq` until a nonzero value is written.
- R6: A read of 0xC01 accepted in cycle t returns T0-2, or 0 when T0 < 3, where T0 is the timer value during cycle t.
- R7: The retired counter (CSR 0xC02) rises by one in each clock where `retire_vld` is 1 and `retire_nop` is 0, and is otherwise unchanged. A read of it returns its value during the request cycle.
- R8: A write (`wr_en` with a matching `wr_addr`) has priority over the count update in the same clock. The written value is the counter value in the next cycle, and the timer does not pulse `timer_irq` in that cycle.
- R9: A read of any other address returns 0. A write to any other address changes none of the counters.
- R10: Reads in consecutive cycles each return their own result, in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| rd_en | input | 1 | CSR read request for this cycle |
| rd_addr | input | AW | CSR number to read |
| rd_vld | output | 1 | Read result valid, two cycles after the request |
| rd_data | output | DW | Skewed counter value for the read |
| wr_en | input | 1 | CSR write request for this cycle |
| wr_addr | input | AW | CSR number to write |
| wr_data | input | DW | Value to load |
| retire_vld | input | 1 | An instruction leaves the last pipeline stage |
| retire_nop | input | 1 | The retiring instruction is a NOP |
| timer_irq | output | 1 | One-cycle timer expiry request |

## Verification
The assertions check the following on every cycle:
- the cycle counter steps by one whenever no write reached it;
- the retired counter holds still without a counted retirement or a write;
- a zero timer stays at zero;
- the interrupt is a single cycle and occurs only while the timer is zero;
- the read-valid strobe trails the request by exactly two cycles.

The returned values themselves need the bench's scenarios. These cover the timer skew around T0 = 0 to 4, cycle wrap-around, a write landing in the same clock as a retirement, back-to-back reads, and ignored addresses. A reference model tracks what the counters should hold, and a scoreboard compares every read result and every interrupt cycle against it.

// File: rtl/ctr_csr_pkg.sv
package ctr_csr_pkg;
  localparam logic [11:0] CSR_NUM_CYCLE   = 12'hC00;
  localparam logic [11:0] CSR_NUM_TIMER   = 12'hC01;
  localparam logic [11:0] CSR_NUM_INSTRET = 12'hC02;
  // pipeline distance between fetch of the read and the value it reports
  localparam int unsigned RD_SKEW = 2;

  typedef enum logic [1:0] {
    SEL_NONE    = 2'd0,
    SEL_CYCLE   = 2'd1,
    SEL_TIMER   = 2'd2,
    SEL_INSTRET = 2'd3
  } ctr_sel_e;
endpackage

// File: rtl/ctr_up.sv
module ctr_up #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  output logic [DW-1:0] cnt
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // load wins over increment
  always_comb begin
    cnt_en = ld | inc;
    cnt_d  = ld ? ld_val : cnt_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ctr_down_irq.sv
module ctr_down_irq #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  output logic [DW-1:0] cnt,
  output logic          irq
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          irq_q, irq_d;
  logic          nonzero;

  always_comb begin
    nonzero = |cnt_q;
    cnt_en  = ld | nonzero;
    cnt_d   = ld ? ld_val : cnt_q - DW'(1);
    // expiry only on a natural 1 -> 0 step, never on a load
    irq_d   = !ld && (cnt_q == DW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign cnt = cnt_q;
  assign irq = irq_q;
endmodule

// File: rtl/ctr_rd_pipe.sv
module ctr_rd_pipe #(
  parameter int DW  = 32,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [DW-1:0] in_data,
  output logic          out_vld,
  output logic [DW-1:0] out_data
);
  logic          vld_q [LAT];
  logic [DW-1:0] dat_q [LAT];

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    logic          vld_d;
    logic [DW-1:0] dat_d;
    if (s == 0) begin : g_head
      assign vld_d = in_vld;
      assign dat_d = in_data;
    end else begin : g_body
      assign vld_d = vld_q[s-1];
      assign dat_d = dat_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q[s] <= 1'b0;
      else        vld_q[s] <= vld_d;
    end

    // data only moves with a valid beat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dat_q[s] <= '0;
      else if (vld_d) dat_q[s] <= dat_d;
    end
  end

  assign out_vld  = vld_q[LAT-1];
  assign out_data = vld_q[LAT-1] ? dat_q[LAT-1] : '0;
endmodule

// File: rtl/ctr_csr_unit.sv
module ctr_csr_unit
  import ctr_csr_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_vld,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          retire_vld,
  input  logic          retire_nop,
  output logic          timer_irq
);
  localparam logic [DW-1:0] SKEW_V = DW'(RD_SKEW);

  logic [DW-1:0] cyc_q, tmr_q, ins_q;
  logic          ld_cyc, ld_tmr, ld_ins;
  logic          ins_inc;
  ctr_sel_e      rd_sel;
  logic [DW-1:0] rd_val;

  function automatic ctr_sel_e decode(input logic [AW-1:0] a);
    if      (a == AW'(CSR_NUM_CYCLE))   return SEL_CYCLE;
    else if (a == AW'(CSR_NUM_TIMER))   return SEL_TIMER;
    else if (a == AW'(CSR_NUM_INSTRET)) return SEL_INSTRET;
    else                                return SEL_NONE;
  endfunction

  always_comb begin
    ld_cyc  = wr_en && (decode(wr_addr) == SEL_CYCLE);
    ld_tmr  = wr_en && (decode(wr_addr) == SEL_TIMER);
    ld_ins  = wr_en && (decode(wr_addr) == SEL_INSTRET);
    ins_inc = retire_vld && !retire_nop;
    rd_sel  = decode(rd_addr);
  end

  // value the read will report once it has travelled RD_SKEW stages
  always_comb begin
    unique case (rd_sel)
      SEL_CYCLE:   rd_val = cyc_q + SKEW_V;
      SEL_TIMER:   rd_val = (tmr_q <= SKEW_V) ? '0 : tmr_q - SKEW_V;
      SEL_INSTRET: rd_val = ins_q;
      default:     rd_val = '0;
    endcase
  end

  ctr_up #(.DW(DW)) u_cycle (
    .clk(clk), .rst_n(rst_n), .inc(1'b1), .ld(ld_cyc), .ld_val(wr_data), .cnt(cyc_q)
  );

  ctr_down_irq #(.DW(DW)) u_timer (
    .clk(clk), .rst_n(rst_n), .ld(ld_tmr), .ld_val(wr_data), .cnt(tmr_q), .irq(timer_irq)
  );

  ctr_up #(.DW(DW)) u_instret (
    .clk(clk), .rst_n(rst_n), .inc(ins_inc), .ld(ld_ins), .ld_val(wr_data), .cnt(ins_q)
  );

  ctr_rd_pipe #(.DW(DW), .LAT(RD_SKEW)) u_rd_pipe (
    .clk(clk), .rst_n(rst_n), .in_vld(rd_en), .in_data(rd_val),
    .out_vld(rd_vld), .out_data(rd_data)
  );
endmodule

// File: rtl/ctr_csr_unit_chk.sv
module ctr_csr_unit_chk
  import ctr_csr_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          rd_vld,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          retire_vld,
  input logic          retire_nop,
  input logic          timer_irq,
  input logic [DW-1:0] cyc_q,
  input logic [DW-1:0] tmr_q,
  input logic [DW-1:0] ins_q
);
  // clocks seen since reset release, saturating
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  logic w_cyc, w_tmr, w_ins, cnt_ret;
  always_comb begin
    w_cyc   = wr_en && (wr_addr == AW'(CSR_NUM_CYCLE));
    w_tmr   = wr_en && (wr_addr == AW'(CSR_NUM_TIMER));
    w_ins   = wr_en && (wr_addr == AW'(CSR_NUM_INSTRET));
    cnt_ret = retire_vld && !retire_nop;
  end

  p_cycle_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && !$past(w_cyc)) |-> (cyc_q == $past(cyc_q) + DW'(1)));

  p_rd_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd2) |-> (rd_vld == $past(rd_en, 2)));

  p_irq_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timer_irq |-> (tmr_q == '0));

  p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timer_irq |=> !timer_irq);

  p_timer_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && $past(tmr_q) == '0 && !$past(w_tmr)) |-> (tmr_q == '0 && !timer_irq));

  p_instret_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && !$past(cnt_ret) && !$past(w_ins)) |-> $stable(ins_q));
endmodule

bind ctr_csr_unit ctr_csr_unit_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_vld(rd_vld),
  .wr_en(wr_en), .wr_addr(wr_addr), .retire_vld(retire_vld), .retire_nop(retire_nop),
  .timer_irq(timer_irq), .cyc_q(cyc_q), .tmr_q(tmr_q), .ins_q(ins_q)
);

// File: tb/ctr_csr_unit_tb.sv
module ctr_csr_unit_tb;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam logic [AW-1:0] A_CYC = 12'hC00;
  localparam logic [AW-1:0] A_TMR = 12'hC01;
  localparam logic [AW-1:0] A_INS = 12'hC02;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rd_en, wr_en, retire_vld, retire_nop;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wr_data;
  logic          rd_vld, timer_irq;
  logic [DW-1:0] rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  ctr_csr_unit #(.DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_vld(rd_vld),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .retire_vld(retire_vld), .retire_nop(retire_nop), .timer_irq(timer_irq)
  );

  typedef struct {
    logic [DW-1:0] val;
    longint        due;
    string         tag;
  } item_t;

  item_t  sb[$];
  string  cur_tag = "R3";
  longint n_clk = 0;
  logic [DW-1:0] m_cyc, m_tmr, m_ins;
  logic          m_irq;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference model and scoreboard feed, built from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cyc <= '0; m_tmr <= '0; m_ins <= '0; m_irq <= 1'b0; n_clk <= 0;
    end else begin
      if (rd_en) begin
        item_t it;
        it.due = n_clk + 2;
        it.tag = cur_tag;
        if (rd_addr == A_CYC)      it.val = m_cyc + 32'd2;
        else if (rd_addr == A_TMR) it.val = (m_tmr < 3) ? 32'd0 : m_tmr - 32'd2;
        else if (rd_addr == A_INS) it.val = m_ins;
        else                       it.val = 32'd0;
        sb.push_back(it);
      end
      n_clk <= n_clk + 1;
      m_cyc <= (wr_en && wr_addr == A_CYC) ? wr_data : m_cyc + 32'd1;
      if (wr_en && wr_addr == A_TMR)  m_tmr <= wr_data;
      else if (m_tmr != 0)            m_tmr <= m_tmr - 32'd1;
      m_irq <= !(wr_en && wr_addr == A_TMR) && (m_tmr == 32'd1);
      if (wr_en && wr_addr == A_INS)         m_ins <= wr_data;
      else if (retire_vld && !retire_nop)    m_ins <= m_ins + 32'd1;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sb.size() > 0 && sb[0].due == n_clk) begin
        item_t it;
        it = sb.pop_front();
        chk({it.tag, " rd_vld"}, {31'd0, rd_vld}, 32'd1);
        chk({it.tag, " rd_data"}, rd_data, it.val);
      end else if (rd_vld) begin
        chk("R3 unexpected rd_vld", {31'd0, rd_vld}, 32'd0);
      end
      if (timer_irq || m_irq)
        chk("R4 timer_irq", {31'd0, timer_irq}, {31'd0, m_irq});
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string tag);
    cur_tag = tag; rd_en = 1'b1; rd_addr = a;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rd_en = 0; wr_en = 0; retire_vld = 0; retire_nop = 0;
    rd_addr = '0; wr_addr = '0; wr_data = '0;
    tick(3);
    // R1: outputs quiet in reset and just after release
    chk("R1 irq in reset", {31'd0, timer_irq}, 32'd0);
    chk("R1 rd_vld in reset", {31'd0, rd_vld}, 32'd0);
    rst_n = 1'b1;
    tick();
    chk("R1 irq after reset", {31'd0, timer_irq}, 32'd0);
    do_read(A_TMR, "R1 timer");
    do_read(A_INS, "R1 instret");
    do_read(A_CYC, "R2,R3 cycle");
    tick(5);
    do_read(A_CYC, "R2,R3 cycle later");

    // R7: counted and NOP retirements
    retire_vld = 1; retire_nop = 0; tick(5);
    retire_nop = 1; tick(3);
    retire_vld = 0; retire_nop = 0; tick(2);
    do_read(A_INS, "R7 instret");
    retire_vld = 1; tick(2);
    do_read(A_INS, "R7 instret live");
    // R8: write collides with counted retirement
    do_write(A_INS, 32'd100);
    retire_vld = 0;
    do_read(A_INS, "R8 instret write wins");

    // R2/R8: cycle write and wrap
    do_write(A_CYC, 32'hFFFF_FFFC);
    do_read(A_CYC, "R8 cycle write");
    do_read(A_CYC, "R2 cycle wrap");
    do_read(A_CYC, "R2 cycle wrap2");
    tick(2);

    // R6/R10: timer skew across T0 = 4..0 with back-to-back reads
    do_write(A_TMR, 32'd4);
    for (int i = 0; i < 7; i++) do_read(A_TMR, "R6,R10 timer");
    tick(3);
    do_read(A_TMR, "R5 timer expired");
    // R5: write zero disables
    do_write(A_TMR, 32'd9);
    tick(3);
    do_write(A_TMR, 32'd0);
    tick(15);
    do_read(A_TMR, "R5 timer disabled");
    // R4: shortest expiry
    do_write(A_TMR, 32'd1);
    tick(4);
    // R8: reload while at 1 suppresses the pulse
    do_write(A_TMR, 32'd2);
    tick(1);
    do_write(A_TMR, 32'd6);
    tick(10);
    // long run
    do_write(A_TMR, 32'd40);
    tick(20);
    do_read(A_TMR, "R6 timer mid");
    tick(30);

    // R9: unknown address
    do_read(12'h123, "R9 unknown read");
    do_write(12'h123, 32'hDEAD_BEEF);
    do_write(12'hC03, 32'h5);
    do_read(A_INS, "R9 instret untouched");
    do_read(A_TMR, "R9 timer untouched");
    do_read(A_CYC, "R9 cycle untouched");
    do_read(12'hC03, "R9 unknown read2");
    tick(6);
    chk("R3 scoreboard drained", 32'(sb.size()), 32'd0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule